// File: doc/BRIEF.md
# Configurable Add/Subtract Cell with Per-Bit Carry and Propagate Outputs

This block is a purely combinational arithmetic cell. It takes two operands of independent widths and brings both to the result width. Each operand is sign-filled or zero-filled according to its own signedness parameter, or cut down to its low bits when it is wider than the result. Two single-bit controls select the operation. One inverts the second operand. The other injects a carry into bit zero. With these two controls the same cell adds, subtracts, or increments.

Besides the sum, the cell drives two vectors as wide as the result. The first is a per-bit propagate term, the XOR of the two effective operand bits. The second is a per-bit carry vector, where each bit is the carry leaving that bit position. Downstream logic can use these vectors to build comparison or overflow terms without redoing the addition. There is no clock and no reset: every output follows its inputs.

Top module: `alu_addsub_cell`

## Requirements
- R1: When the result is wider than an operand, that operand's upper bits are filled with its top bit if its signedness parameter is 1, and with zeros if it is 0. A and B each follow their own parameter.
- R2: When an operand is wider than the result, only its low Y_WIDTH bits take part, and its upper bits have no effect on any output.
- R3: With `invertB` = 1 every bit of the extended B is complemented before use. With `invertB` = 0 the extended B is used unchanged.
- R4: `sum` equals extended A plus effective B plus `carryIn`, modulo 2^Y_WIDTH.
- R5: `propagate[i]` equals A[i] XOR effective B[i] for every bit, and it does not change with `carryIn`.
- R6: `carryVec[i]` is the carry out of bit position i, which is the majority of A[i], effective B[i] and the carry into bit i. The carry into bit 0 is `carryIn`. `carryVec[Y_WIDTH-1]` equals bit Y_WIDTH of the full-width sum.
- R7: With `invertB` = 1 and `carryIn` = 1, `sum` equals extended A minus extended B in two's complement, modulo 2^Y_WIDTH.
- R8: The outputs settle from the inputs alone, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | A_WIDTH | First operand |
| opB | input | B_WIDTH | Second operand, optionally complemented |
| carryIn | input | 1 | Carry into bit 0 |
| invertB | input | 1 | 1 complements the extended second operand |
| sum | output | Y_WIDTH | Result of the addition |
| propagate | output | Y_WIDTH | Per-bit XOR of the effective operands |
| carryVec | output | Y_WIDTH | Carry out of each bit position |

## Verification
Immediate assertions run whenever an input changes. They check four things: that the rippled sum and top carry agree with a plain arithmetic addition, that the sum, propagate and carry vectors fit together bit by bit, that the complement applies uniformly across the word, and that widening keeps the signed or unsigned operand value. Some behaviours cannot be seen from inside one instance, so only the bench's scenarios show them. These are the choice between sign fill and zero fill across the four signedness pairings, the truncation of a wide operand, and the independence of the propagate vector from the carry input. The bench covers them with four differently parameterized instances and with extreme operand values.

// File: rtl/alu_cell_pkg.sv
package alu_cell_pkg;
  // Control strobes handed from the control decode to the datapath.
  typedef struct packed {
    logic invB;     // complement the extended second operand
    logic carryIn;  // carry injected at bit 0
  } aluStrobeT;
endpackage

// File: rtl/alu_cell_ctrl.sv
module alu_cell_ctrl
  import alu_cell_pkg::*;
(
  input  logic      invertB,
  input  logic      carryIn,
  output aluStrobeT strobes
);
  always_comb begin
    strobes.invB    = invertB;
    strobes.carryIn = carryIn;
  end
endmodule

// File: rtl/alu_cell_extend.sv
module alu_cell_extend #(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 8,
  parameter bit IS_SIGNED = 1'b0
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] ext
);
  generate
    if (IN_W >= OUT_W) begin : g_trunc
      // keep only the low result-width bits (R2)
      assign ext = raw[OUT_W-1:0];
    end else begin : g_widen
      localparam int FILL_W = OUT_W - IN_W;
      logic fillBit;
      assign fillBit = IS_SIGNED ? raw[IN_W-1] : 1'b0;
      assign ext     = {{FILL_W{fillBit}}, raw};

      always_comb begin
        if (IS_SIGNED) begin
          AST_SIGNED_VALUE_KEPT: assert ($signed(ext) == OUT_W'($signed(raw)));  // R1
        end else begin
          AST_UNSIGNED_VALUE_KEPT: assert (ext == OUT_W'(raw));  // R1
        end
      end
    end
  endgenerate
endmodule

// File: rtl/alu_cell_datapath.sv
module alu_cell_datapath
  import alu_cell_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] aExt,
  input  logic [W-1:0] bExt,
  input  aluStrobeT    strobes,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] propOut,
  output logic [W-1:0] carryOut
);
  logic [W:0]   chain;
  logic [W-1:0] bEff;
  logic [W:0]   wideSum;
  logic [W:0]   carryIntoBit;

  always_comb begin
    bEff     = strobes.invB ? ~bExt : bExt;
    chain    = '0;
    chain[0] = strobes.carryIn;
    sumOut   = '0;
    propOut  = '0;
    carryOut = '0;
    for (int i = 0; i < W; i++) begin
      propOut[i]  = aExt[i] ^ bEff[i];
      sumOut[i]   = propOut[i] ^ chain[i];
      chain[i+1]  = (aExt[i] & bEff[i]) | (aExt[i] & chain[i]) | (bEff[i] & chain[i]);
      carryOut[i] = chain[i+1];
    end

    // checks on the settled values of this evaluation
    wideSum      = {1'b0, aExt} + {1'b0, bEff} + (W+1)'(strobes.carryIn);
    carryIntoBit = {carryOut, strobes.carryIn};
    AST_SUM_ARITH: assert ({carryOut[W-1], sumOut} == wideSum);  // R4
    AST_SUM_PROP_CARRY: assert ((sumOut ^ propOut) == carryIntoBit[W-1:0]);  // R6
    AST_INV_UNIFORM: assert ((propOut ^ aExt ^ bExt) == {W{strobes.invB}});  // R3
    if (strobes.invB && strobes.carryIn) begin
      AST_SUB_DIFF: assert (sumOut == W'(aExt - bExt));  // R7
    end
  end
endmodule

// File: rtl/alu_addsub_cell.sv
module alu_addsub_cell
  import alu_cell_pkg::*;
#(
  parameter int A_WIDTH  = 8,
  parameter int B_WIDTH  = 8,
  parameter int Y_WIDTH  = 8,
  parameter bit A_SIGNED = 1'b0,
  parameter bit B_SIGNED = 1'b0
) (
  input  logic [A_WIDTH-1:0] opA,
  input  logic [B_WIDTH-1:0] opB,
  input  logic               carryIn,
  input  logic               invertB,
  output logic [Y_WIDTH-1:0] sum,
  output logic [Y_WIDTH-1:0] propagate,
  output logic [Y_WIDTH-1:0] carryVec
);
  aluStrobeT          strobes;
  logic [Y_WIDTH-1:0] aExt;
  logic [Y_WIDTH-1:0] bExt;

  alu_cell_ctrl u_ctrl (
    .invertB (invertB),
    .carryIn (carryIn),
    .strobes (strobes)
  );

  alu_cell_extend #(.IN_W(A_WIDTH), .OUT_W(Y_WIDTH), .IS_SIGNED(A_SIGNED)) u_extA (
    .raw (opA),
    .ext (aExt)
  );

  alu_cell_extend #(.IN_W(B_WIDTH), .OUT_W(Y_WIDTH), .IS_SIGNED(B_SIGNED)) u_extB (
    .raw (opB),
    .ext (bExt)
  );

  alu_cell_datapath #(.W(Y_WIDTH)) u_dp (
    .aExt     (aExt),
    .bExt     (bExt),
    .strobes  (strobes),
    .sumOut   (sum),
    .propOut  (propagate),
    .carryOut (carryVec)
  );
endmodule

// File: tb/alu_addsub_cell_tb.sv
module alu_addsub_cell_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5ns clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [15:0] rawA, rawB;
  logic        ci, bi;

  // instance table: A width, B width, Y width, A signed, B signed
  localparam int AW [4] = '{8, 8, 12, 4};
  localparam int BW [4] = '{5, 5, 6, 9};
  localparam int YW [4] = '{10, 10, 8, 9};
  localparam bit AS [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam bit BS [4] = '{1'b1, 1'b0, 1'b0, 1'b1};

  logic [9:0] y0, x0, c0;
  logic [9:0] y1, x1, c1;
  logic [7:0] y2, x2, c2;
  logic [8:0] y3, x3, c3;

  alu_addsub_cell #(.A_WIDTH(8), .B_WIDTH(5), .Y_WIDTH(10), .A_SIGNED(1'b1), .B_SIGNED(1'b1)) u_dut (
    .opA(rawA[7:0]), .opB(rawB[4:0]), .carryIn(ci), .invertB(bi), .sum(y0), .propagate(x0), .carryVec(c0));
  alu_addsub_cell #(.A_WIDTH(8), .B_WIDTH(5), .Y_WIDTH(10), .A_SIGNED(1'b0), .B_SIGNED(1'b0)) u_dut_uu (
    .opA(rawA[7:0]), .opB(rawB[4:0]), .carryIn(ci), .invertB(bi), .sum(y1), .propagate(x1), .carryVec(c1));
  alu_addsub_cell #(.A_WIDTH(12), .B_WIDTH(6), .Y_WIDTH(8), .A_SIGNED(1'b1), .B_SIGNED(1'b0)) u_dut_su (
    .opA(rawA[11:0]), .opB(rawB[5:0]), .carryIn(ci), .invertB(bi), .sum(y2), .propagate(x2), .carryVec(c2));
  alu_addsub_cell #(.A_WIDTH(4), .B_WIDTH(9), .Y_WIDTH(9), .A_SIGNED(1'b0), .B_SIGNED(1'b1)) u_dut_us (
    .opA(rawA[3:0]), .opB(rawB[8:0]), .carryIn(ci), .invertB(bi), .sum(y3), .propagate(x3), .carryVec(c3));

  function automatic logic [31:0] lowMask(int w);
    return (32'h1 << w) - 32'h1;
  endfunction

  function automatic logic [31:0] extendVal(logic [31:0] v, int inW, int outW, bit sg);
    logic [31:0] r;
    r = v & lowMask(inW);
    if (sg && r[inW-1]) r = r | ~lowMask(inW);
    return r & lowMask(outW);
  endfunction

  task automatic checkVal(string tag, int inst, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s inst%0d a=%h b=%h ci=%0b bi=%0b actual=%h expected=%h",
               tag, inst, rawA, rawB, ci, bi, act, exp);
    end
  endtask

  task automatic checkInst(int k);
    logic [31:0] a, b, bEff, m, mi, expY, expX, expC, gotY, gotX, gotC;
    logic [32:0] s;
    m = lowMask(YW[k]);
    a = extendVal({16'h0, rawA}, AW[k], YW[k], AS[k]);
    b = extendVal({16'h0, rawB}, BW[k], YW[k], BS[k]);
    bEff = bi ? (~b & m) : b;
    s = {1'b0, a} + {1'b0, bEff} + {32'h0, ci};
    expY = s[31:0] & m;
    expX = (a ^ bEff) & m;
    expC = '0;
    for (int i = 0; i < YW[k]; i++) begin
      logic [32:0] ps;
      mi = lowMask(i + 1);
      ps = {1'b0, a & mi} + {1'b0, bEff & mi} + {32'h0, ci};
      expC[i] = ps[i+1];
    end
    case (k)
      0: begin gotY = 32'(y0); gotX = 32'(x0); gotC = 32'(c0); end
      1: begin gotY = 32'(y1); gotX = 32'(x1); gotC = 32'(c1); end
      2: begin gotY = 32'(y2); gotX = 32'(x2); gotC = 32'(c2); end
      default: begin gotY = 32'(y3); gotX = 32'(x3); gotC = 32'(c3); end
    endcase
    checkVal((bi && ci) ? "R4/R7 sum" : "R4 sum", k, gotY, expY);
    checkVal("R5 propagate", k, gotX, expX);
    checkVal("R6 carry vector", k, gotC, expC);
  endtask

  task automatic applyAndCheck(logic [15:0] a, logic [15:0] b, logic c, logic inv);
    @(posedge clk);
    rawA = a; rawB = b; ci = c; bi = inv;
    @(negedge clk);
    for (int k = 0; k < 4; k++) checkInst(k);
  endtask

  initial begin
    #(200000 * 5ns);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] corners [8];
    logic [9:0]  xRef;
    process::self().srandom(32'd1234);
    corners = '{16'h0000, 16'hFFFF, 16'h0080, 16'h0800, 16'h0008, 16'h0010, 16'h0020, 16'h0100};
    rawA = '0; rawB = '0; ci = 1'b0; bi = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // quiescent state: all-zero inputs give all-zero outputs (R4)
    @(negedge clk);
    checkVal("R4 idle sum", 0, 32'(y0), 32'h0);
    checkVal("R6 idle carry", 0, 32'(c0), 32'h0);

    // R1: most negative 8-bit A, signed vs unsigned fill
    applyAndCheck(16'h0080, 16'h0000, 1'b0, 1'b0);
    checkVal("R1 sign fill", 0, 32'(y0), 32'h380);
    checkVal("R1 zero fill", 1, 32'(y1), 32'h080);
    // R1 on B: 5-bit B = 5'h10
    applyAndCheck(16'h0000, 16'h0010, 1'b0, 1'b0);
    checkVal("R1 B sign fill", 0, 32'(y0), 32'h3F0);
    checkVal("R1 B zero fill", 1, 32'(y1), 32'h010);

    // R2: high bits of 12-bit A beyond 8-bit result are dropped
    applyAndCheck(16'h0F05, 16'h0000, 1'b0, 1'b0);
    checkVal("R2 truncate", 2, 32'(y2), 32'h05);
    applyAndCheck(16'h0A05, 16'h0000, 1'b0, 1'b0);
    checkVal("R2 upper bits ignored", 2, 32'(y2), 32'h05);

    // R3: inverting zero B gives all ones
    applyAndCheck(16'h0000, 16'h0000, 1'b0, 1'b1);
    checkVal("R3 invert B", 1, 32'(y1), 32'h3FF);
    checkVal("R3 propagate all ones", 1, 32'(x1), 32'h3FF);

    // R7: 5 - 7 = -2
    applyAndCheck(16'h0005, 16'h0007, 1'b1, 1'b1);
    checkVal("R7 subtract", 0, 32'(y0), 32'h3FE);

    // R5: propagate unchanged when only carryIn toggles
    applyAndCheck(16'h00A5, 16'h0013, 1'b0, 1'b0);
    xRef = x0;
    @(posedge clk); ci = 1'b1;
    @(negedge clk);
    checkVal("R5 propagate vs carryIn", 0, 32'(x0), 32'(xRef));

    // R8: outputs follow inputs with no clock edge in between
    @(negedge clk);
    #1ns; rawA = 16'h0003; rawB = 16'h0004; ci = 1'b0; bi = 1'b0;
    #1ns;
    checkVal("R8 no clock needed", 1, 32'(y1), 32'h007);

    // corner sweep: extremes and most-negative values, all control combos
    for (int ia = 0; ia < 8; ia++)
      for (int ib = 0; ib < 8; ib++)
        for (int cc = 0; cc < 4; cc++)
          applyAndCheck(corners[ia], corners[ib], cc[0], cc[1]);

    // random stimulus
    for (int n = 0; n < 500; n++)
      applyAndCheck(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule